// File: doc/BRIEF.md
# Transmit Event Interrupt Collector

This block sits next to the transmit engine of a 10 Mb/s Ethernet MAC and turns its single-cycle event strobes into one level-sensitive interrupt request for the host. Every strobe sets a sticky status bit. This happens whatever the enable setting is. The interrupt line is high while any status bit is set and its enable bit is also set. The host reads the status word to learn which events happened, and that read clears the bits it reported.

Two host-writable enable registers choose which events may raise the interrupt. One register serves the transmit-configuration events and the other serves the buffer-configuration events. A write takes effect on the next clock, even in the middle of a frame. The block also keeps a 5-bit count of collisions. When that count wraps, a status event is raised. Reading the count clears it.

Top module: `txirq_ctrl`

## Requirements
- R1: After reset, `stat_q`, `col_cnt` and `irq` are all zero, and both enable registers hold zero.
- R2: Each event strobe sets its own sticky status bit, whether or not that event is enabled. Status bit order, from bit 0 upward: no-carrier, SQE error, transmit OK, late collision, jabber, any collision, 16 attempts, buffer ready, underrun, counter overflow.
- R3: When `cfg_sel`=0, `cfg_wdata` loads the transmit enables. The bit positions are: no-carrier at 6, SQE at 7, transmit OK at 8, late collision at 9, jabber at 10, any collision at 11, and 16 attempts at 15. `irq` is the OR of every status bit ANDed with its enable.
- R4: When `cfg_sel`=1, `cfg_wdata` loads the buffer enables. The bit positions are: buffer ready at 8, underrun at 9, and counter overflow at 12. Bits outside the listed positions are ignored.
- R5: An enable write sets `irq` from the very next clock, even while events keep arriving. A write changes only the register that `cfg_sel` selects.
- R6: The no-carrier strobe sets its status bit only while `aui_sel` is high. Otherwise it has no effect.
- R7: A pulse on `stat_rd` clears every status bit that was set in that cycle. An event strobed in the same cycle as the read stays set afterwards.
- R8: Each `ev_col` pulse increments `col_cnt` modulo 32. A step from 31 to 0 sets the counter-overflow status bit (bit 9).
- R9: A pulse on `cnt_rd` clears `col_cnt`. If a collision arrives in the same cycle, the count becomes 1 and no overflow is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Enable-register write strobe |
| cfg_sel | input | 1 | 0 selects the transmit enables, 1 selects the buffer enables |
| cfg_wdata | input | 16 | Write data |
| aui_sel | input | 1 | High while the attachment-unit port is in use |
| ev_nocrs | input | 1 | No carrier seen after the preamble |
| ev_sqe | input | 1 | SQE test error |
| ev_txok | input | 1 | Frame sent successfully |
| ev_late | input | 1 | Collision outside the window |
| ev_jab | input | 1 | Jabber condition |
| ev_col | input | 1 | Any collision; also increments the counter |
| ev_col16 | input | 1 | Sixteenth attempt on one frame |
| ev_rdy | input | 1 | Buffer space ready for a pending transmit |
| ev_under | input | 1 | Data ran dry after transmit began |
| stat_rd | input | 1 | Status read strobe (clear-on-read) |
| cnt_rd | input | 1 | Counter read strobe (clear-on-read) |
| irq | output | 1 | Interrupt request |
| stat_q | output | 10 | Sticky status bits |
| col_cnt | output | 5 | Collision count |

## Verification
Each event is first strobed on its own, once with its enable cleared and once with it set. A status bit that rises while `irq` stays low shows that recording is separate from gating. Identical strobes that differ only in which register was written show whether the bit positions are correct. A run of SQE strobes with the enable dropped partway through shows whether `irq` follows the new enable on the next clock. Sequences of 32 and more collisions, including reads in the same cycle as events, separate a correct wrap and clear from off-by-one or lost-event faults. Seeded random traffic then mixes all of these.

// File: rtl/txirq_pkg.sv
package txirq_pkg;
  localparam int NEV   = 10;
  localparam int REG_W = 16;

  typedef enum int unsigned {
    EV_NOCRS = 0, EV_SQE, EV_TXOK, EV_LATE, EV_JAB,
    EV_ANYCOL, EV_COL16, EV_RDY, EV_UNDER, EV_OVF
  } ev_idx_e;

  // Transmit-config register: position of each enable bit
  function automatic logic [NEV-1:0] tx_cfg_map(input logic [REG_W-1:0] d,
                                                input logic [NEV-1:0] old);
    logic [NEV-1:0] r;
    r = old;
    r[EV_NOCRS]  = d[6];
    r[EV_SQE]    = d[7];
    r[EV_TXOK]   = d[8];
    r[EV_LATE]   = d[9];
    r[EV_JAB]    = d[10];
    r[EV_ANYCOL] = d[11];
    r[EV_COL16]  = d[15];
    return r;
  endfunction

  // Buffer-config register: position of each enable bit
  function automatic logic [NEV-1:0] buf_cfg_map(input logic [REG_W-1:0] d,
                                                 input logic [NEV-1:0] old);
    logic [NEV-1:0] r;
    r = old;
    r[EV_RDY]   = d[8];
    r[EV_UNDER] = d[9];
    r[EV_OVF]   = d[12];
    return r;
  endfunction

  // Clear-on-read: bits reported in this cycle drop, new events win
  function automatic logic [NEV-1:0] stat_next(input logic [NEV-1:0] cur,
                                               input logic [NEV-1:0] ev,
                                               input logic rd);
    return (rd ? '0 : cur) | ev;
  endfunction
endpackage

// File: rtl/txirq_en_regs.sv
module txirq_en_regs
  import txirq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             sel,
  input  logic [REG_W-1:0] wdata,
  output logic [NEV-1:0]   en_q
);
  logic [NEV-1:0] en_d;

  always_comb begin
    en_d = en_q;
    if (we) en_d = sel ? buf_cfg_map(wdata, en_q) : tx_cfg_map(wdata, en_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  // R5
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(en_q));
endmodule

// File: rtl/txirq_col_cnt.sv
module txirq_col_cnt #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] cnt_q,
  output logic         wrap_o
);
  localparam logic [W-1:0] CMAX = {W{1'b1}};

  function automatic logic [W-1:0] cnt_next(input logic [W-1:0] c,
                                            input logic i, input logic z);
    return (z ? '0 : c) + {{(W-1){1'b0}}, i};
  endfunction

  assign wrap_o = inc && !clr && (cnt_q == CMAX);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_next(cnt_q, inc, clr);
  end

  // R8
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc && !clr |=> cnt_q == W'($past(cnt_q) + 1'b1));
  // R9
  cnt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !inc |=> cnt_q == '0);
endmodule

// File: rtl/txirq_stat.sv
module txirq_stat
  import txirq_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NEV-1:0] ev_i,
  input  logic           rd_i,
  output logic [NEV-1:0] stat_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_next(stat_q, ev_i, rd_i);
  end

  // R2
  stat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> (stat_q & $past(stat_q)) == $past(stat_q));
  // R7
  stat_catch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |ev_i |=> (stat_q & $past(ev_i)) == $past(ev_i));
endmodule

// File: rtl/txirq_ctrl.sv
module txirq_ctrl
  import txirq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [REG_W-1:0] cfg_wdata,
  input  logic             aui_sel,
  input  logic             ev_nocrs,
  input  logic             ev_sqe,
  input  logic             ev_txok,
  input  logic             ev_late,
  input  logic             ev_jab,
  input  logic             ev_col,
  input  logic             ev_col16,
  input  logic             ev_rdy,
  input  logic             ev_under,
  input  logic             stat_rd,
  input  logic             cnt_rd,
  output logic             irq,
  output logic [NEV-1:0]   stat_q,
  output logic [CNT_W-1:0] col_cnt
);
  logic [NEV-1:0] en_q;
  logic [NEV-1:0] ev_vec;
  logic           cnt_wrap;
  logic           nocrs_ok;

  assign nocrs_ok = ev_nocrs & aui_sel;
  assign ev_vec = {cnt_wrap, ev_under, ev_rdy, ev_col16, ev_col,
                   ev_jab, ev_late, ev_txok, ev_sqe, nocrs_ok};

  txirq_en_regs u_en (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
    .wdata(cfg_wdata), .en_q(en_q));

  txirq_col_cnt #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(ev_col), .clr(cnt_rd),
    .cnt_q(col_cnt), .wrap_o(cnt_wrap));

  txirq_stat u_stat (
    .clk(clk), .rst_n(rst_n), .ev_i(ev_vec), .rd_i(stat_rd),
    .stat_q(stat_q));

  assign irq = |(stat_q & en_q);

  // R8
  ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wrap |=> stat_q[EV_OVF]);
  // R6
  nocrs_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !aui_sel && !stat_q[EV_NOCRS] |=> !stat_q[EV_NOCRS]);
  // R3
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we && !stat_rd && !(|ev_vec) |=> $stable(irq));
endmodule

// File: tb/txirq_ctrl_tb.sv
`timescale 1ns/1ps
module txirq_ctrl_tb_top;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_sel = 0, aui_sel = 0;
  logic [15:0] cfg_wdata = '0;
  logic ev_nocrs = 0, ev_sqe = 0, ev_txok = 0, ev_late = 0, ev_jab = 0;
  logic ev_col = 0, ev_col16 = 0, ev_rdy = 0, ev_under = 0;
  logic stat_rd = 0, cnt_rd = 0;
  logic irq;
  logic [9:0] stat_q;
  logic [4:0] col_cnt;

  int checks = 0, errors = 0;
  logic [9:0] m_stat = '0, m_en = '0;
  logic [4:0] m_cnt = '0;
  int txpos [7] = '{6, 7, 8, 9, 10, 11, 15};
  int bufpos [3] = '{8, 9, 12};

  always #5 clk = ~clk;

  txirq_ctrl dut_i (.*);

  function automatic logic [9:0] apply_wr(logic [9:0] en, logic sel, logic [15:0] d);
    logic [9:0] r = en;
    if (!sel) for (int k = 0; k < 7; k++) r[k] = d[txpos[k]];
    else      for (int k = 0; k < 3; k++) r[7+k] = d[bufpos[k]];
    return r;
  endfunction

  function automatic logic [15:0] en_word(int idx);
    logic [15:0] w = '0;
    if (idx < 7) w[txpos[idx]] = 1'b1;
    else         w[bufpos[idx-7]] = 1'b1;
    return w;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic clear_in();
    cfg_we = 0; ev_nocrs = 0; ev_sqe = 0; ev_txok = 0; ev_late = 0; ev_jab = 0;
    ev_col = 0; ev_col16 = 0; ev_rdy = 0; ev_under = 0; stat_rd = 0; cnt_rd = 0;
  endtask

  task automatic step(string tag);
    logic ovf;
    logic [9:0] ev;
    @(posedge clk);
    ovf = ev_col && !cnt_rd && (m_cnt == 5'd31);
    ev = {ovf, ev_under, ev_rdy, ev_col16, ev_col, ev_jab, ev_late, ev_txok,
          ev_sqe, ev_nocrs && aui_sel};
    m_stat = (stat_rd ? 10'd0 : m_stat) | ev;
    m_cnt  = (cnt_rd ? 5'd0 : m_cnt) + {4'd0, ev_col};
    if (cfg_we) m_en = apply_wr(m_en, cfg_sel, cfg_wdata);
    @(negedge clk);
    chk(tag, "stat", {22'd0, stat_q}, {22'd0, m_stat});
    chk(tag, "cnt", {27'd0, col_cnt}, {27'd0, m_cnt});
    chk(tag, "irq", {31'd0, irq}, {31'd0, |(m_stat & m_en)});
    clear_in();
  endtask

  task automatic wr(logic sel, logic [15:0] d, string tag);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = d; step(tag);
  endtask

  task automatic strobe(int idx);
    case (idx)
      0: ev_nocrs = 1; 1: ev_sqe = 1; 2: ev_txok = 1; 3: ev_late = 1;
      4: ev_jab = 1;   5: ev_col = 1; 6: ev_col16 = 1; 7: ev_rdy = 1;
      default: ev_under = 1;
    endcase
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    chk("R1", "stat", {22'd0, stat_q}, 32'd0);
    chk("R1", "cnt", {27'd0, col_cnt}, 32'd0);
    chk("R1", "irq", {31'd0, irq}, 32'd0);
    aui_sel = 1;
    // R2 R3 R4: each event alone, enable off then on
    for (int i = 0; i < 9; i++) begin
      wr(0, 16'h0, "R3"); wr(1, 16'h0, "R4");
      strobe(i); step("R2");
      chk("R2", "bit set", {31'd0, stat_q[i]}, 32'd1);
      chk("R3", "irq off", {31'd0, irq}, 32'd0);
      stat_rd = 1; step("R7"); cnt_rd = 1; step("R9");
      wr(i >= 7, en_word(i), i >= 7 ? "R4" : "R3");
      strobe(i); step(i >= 7 ? "R4" : "R3");
      chk(i >= 7 ? "R4" : "R3", "irq on", {31'd0, irq}, 32'd1);
      stat_rd = 1; step("R7"); cnt_rd = 1; step("R9");
    end
    // R4: unlisted bits ignored
    wr(1, ~16'h1300, "R4"); ev_rdy = 1; ev_under = 1; step("R4");
    chk("R4", "irq unlisted", {31'd0, irq}, 32'd0);
    stat_rd = 1; step("R7");
    // R6: no-carrier ignored without AUI
    wr(0, 16'hFFFF, "R6"); aui_sel = 0; ev_nocrs = 1; step("R6");
    chk("R6", "nocrs gated", {31'd0, stat_q[0]}, 32'd0);
    chk("R6", "irq", {31'd0, irq}, 32'd0);
    aui_sel = 1;
    // R5: enable toggled mid-burst, other register untouched
    wr(0, 16'h0080, "R5");
    for (int k = 0; k < 6; k++) begin
      ev_sqe = 1;
      if (k == 3) begin cfg_we = 1; cfg_sel = 0; cfg_wdata = 16'h0; end
      if (k == 5) begin cfg_we = 1; cfg_sel = 1; cfg_wdata = 16'h1000; end
      step("R5");
      chk("R5", "irq burst", {31'd0, irq}, {31'd0, k < 3});
    end
    // R7: read with same-cycle event
    stat_rd = 1; ev_txok = 1; step("R7");
    chk("R7", "kept", {22'd0, stat_q}, 32'h004);
    stat_rd = 1; step("R7");
    // R8: wrap
    cnt_rd = 1; step("R9");
    for (int k = 0; k < 32; k++) begin ev_col = 1; step("R8"); end
    chk("R8", "wrap cnt", {27'd0, col_cnt}, 32'd0);
    chk("R8", "ovf bit", {31'd0, stat_q[9]}, 32'd1);
    chk("R8", "ovf irq", {31'd0, irq}, 32'd1);
    stat_rd = 1; step("R7");
    // R9: clear with same-cycle collision
    for (int k = 0; k < 31; k++) begin ev_col = 1; step("R8"); end
    cnt_rd = 1; ev_col = 1; step("R9");
    chk("R9", "clr+inc", {27'd0, col_cnt}, 32'd1);
    chk("R9", "no ovf", {31'd0, stat_q[9]}, 32'd0);
    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r = $urandom;
      aui_sel = r[0]; ev_nocrs = r[1]; ev_sqe = r[2] & r[3]; ev_txok = r[4] & r[5];
      ev_late = r[6] & r[7]; ev_jab = r[8] & r[9]; ev_col = r[10];
      ev_col16 = r[11] & r[12]; ev_rdy = r[13] & r[14]; ev_under = r[15] & r[16];
      stat_rd = (r[19:17] == 0); cnt_rd = (r[23:20] == 0);
      cfg_we = (r[26:24] == 0); cfg_sel = r[27]; cfg_wdata = $urandom;
      step("R2 R3 R5 R7 R8");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule